// File: doc/BRIEF.md
# Byte-Written Scratch Mailbox with Sink Interrupt

This block sits inside an audio codec and gives a host driver a narrow path for handing a 32-bit status word to a neighbouring display engine. The host issues commands made of a node id, a 12-bit verb and an 8-bit payload. Verbs either read a whole 32-bit scratch word or overwrite one byte of it. Every scratch node holds two such words. The display side sees every word continuously, together with a pending interrupt flag that it clears with an acknowledge pulse.

A mode strap selects between two arrangements. In toggle mode there is one register pair, reached at node 0x01. The interrupt fires when a byte-3 write to word 0 changes bit 31. In converter mode every converter node, numbered upward from a base id, has its own pair. A dedicated verb with a nonzero payload raises the interrupt, and bit 31 is plain storage. Word 0 conventionally carries a format code in bits 15:0 and a valid flag in bit 30. The block treats those bits as ordinary storage.

Top module: `scratch_mailbox`

## Requirements
- R1: While reset is asserted and after it is released, every scratch word reads zero, no interrupt is pending and no response strobe is present.
- R2: Each command accepted on `cmd_valid_i` produces `rsp_valid_o` high for exactly one cycle, in the cycle after the command. With no command, the strobe stays low.
- R3: Verb 0xFA6 returns all 32 bits of word 0 of the addressed node, and verb 0xFAB returns word 1. The value returned is the one held before that cycle.
- R4: Verbs 0xFA7, 0xFA8, 0xFA9 and 0xFAA write the payload into byte 0, 1, 2 and 3 of word 0. Verbs 0xFAC to 0xFAF do the same for word 1. The other bytes keep their values, and every bit, including the valid flag (bit 30) and the format field (bits 15:0), holds what was written.
- R5: The response word is zero for write verbs, for verb 0xF80 and for unrecognised verbs. An unrecognised verb changes no word and raises no interrupt.
- R6: In toggle mode (`mode_conv_i` = 0), only node 0x01 is answered. A command to any other node returns zero and changes nothing.
- R7: In converter mode (`mode_conv_i` = 1), node `NODE_BASE`+i addresses register pair i for i below `NUM_NODES`. Node 0x01 and nodes outside that range return zero and change nothing.
- R8: In toggle mode, a byte-3 write to word 0 sets the pending flag when payload bit 7 differs from the stored bit 31, in either direction. Writing the same bit 31 again sets nothing.
- R9: In converter mode, verb 0xF80 to an addressed node with a nonzero payload sets the pending flag. A zero payload does not, and a change of bit 31 does not.
- R10: In toggle mode, verb 0xF80 has no effect.
- R11: The pending flag stays set until a cycle with `irq_ack_i` high clears it. If a trigger and an acknowledge fall in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_conv_i | input | 1 | Strap: 0 toggle mode, 1 converter mode |
| cmd_valid_i | input | 1 | One-cycle command strobe |
| cmd_node_i | input | NODE_W | Target node id |
| cmd_verb_i | input | 12 | Verb code |
| cmd_data_i | input | 8 | Payload byte |
| rsp_valid_o | output | 1 | Response strobe, one cycle |
| rsp_data_o | output | 32 | Response word |
| sink_word0_o | output | NUM_NODES*32 | Word 0 of every pair, pair i at bits i*32 upward |
| sink_word1_o | output | NUM_NODES*32 | Word 1 of every pair, same packing |
| irq_pend_o | output | 1 | Pending interrupt to the display side |
| irq_ack_i | input | 1 | One-cycle acknowledge from the display side |

## Verification
Every result of a command is due after exactly one clock edge: the response strobe and word, the updated scratch words and the pending flag all become visible after the edge that samples the command. An acknowledge acts on that same edge. The bench drives each command after a falling edge and advances its reference model by one step. It then waits for the next rising edge and compares every output against the model at the falling edge that follows, so each comparison lands one register stage after its stimulus.

// File: rtl/smb_pkg.sv
package smb_pkg;

   localparam int VERB_W = 12;
   localparam int DATA_W = 8;
   localparam int WORD_W = 32;
   localparam int LANES  = WORD_W / DATA_W;
   localparam int LANE_W = $clog2(LANES);

   localparam logic [VERB_W-1:0] VB_READ_W0  = 12'hFA6;
   localparam logic [VERB_W-1:0] VB_LANE0_W0 = 12'hFA7;
   localparam logic [VERB_W-1:0] VB_READ_W1  = 12'hFAB;
   localparam logic [VERB_W-1:0] VB_LANE0_W1 = 12'hFAC;
   localparam logic [VERB_W-1:0] VB_RAISE    = 12'hF80;

   typedef struct packed {
      logic              rd;
      logic              wr;
      logic              sel1;
      logic [LANE_W-1:0] lane;
      logic              raise;
   } verb_dec_t;

endpackage

// File: rtl/smb_verb_dec.sv
module smb_verb_dec
   import smb_pkg::*;
(
   input  logic [VERB_W-1:0] verb_i,
   output verb_dec_t         dec_o
);

   localparam logic [VERB_W-1:0] LAST_W0 = VB_LANE0_W0 + VERB_W'(LANES - 1);
   localparam logic [VERB_W-1:0] LAST_W1 = VB_LANE0_W1 + VERB_W'(LANES - 1);

   logic [VERB_W-1:0] off0, off1;

   assign off0 = verb_i - VB_LANE0_W0;
   assign off1 = verb_i - VB_LANE0_W1;

   always_comb begin
      dec_o = '0;
      if (verb_i == VB_READ_W0) begin
         dec_o.rd = 1'b1;
      end else if (verb_i == VB_READ_W1) begin
         dec_o.rd   = 1'b1;
         dec_o.sel1 = 1'b1;
      end else if (verb_i >= VB_LANE0_W0 && verb_i <= LAST_W0) begin
         dec_o.wr   = 1'b1;
         dec_o.lane = off0[LANE_W-1:0];
      end else if (verb_i >= VB_LANE0_W1 && verb_i <= LAST_W1) begin
         dec_o.wr   = 1'b1;
         dec_o.sel1 = 1'b1;
         dec_o.lane = off1[LANE_W-1:0];
      end else if (verb_i == VB_RAISE) begin
         dec_o.raise = 1'b1;
      end
   end

endmodule

// File: rtl/smb_node_sel.sv
module smb_node_sel #(
   parameter int                  NUM_NODES   = 2,
   parameter int                  NODE_W      = 8,
   parameter logic [NODE_W-1:0]   NODE_BASE   = 8'h04,
   parameter logic [NODE_W-1:0]   TOGGLE_NODE = 8'h01
) (
   input  logic [NODE_W-1:0]    node_i,
   input  logic                 conv_i,
   output logic [NUM_NODES-1:0] hit_o
);

   for (genvar i = 0; i < NUM_NODES; i++) begin : g_hit
      localparam logic [NODE_W-1:0] MY_ID = NODE_BASE + NODE_W'(i);
      if (i == 0) begin : g_first
         assign hit_o[i] = conv_i ? (node_i == MY_ID) : (node_i == TOGGLE_NODE);
      end else begin : g_rest
         assign hit_o[i] = conv_i && (node_i == MY_ID);
      end
   end

endmodule

// File: rtl/smb_scratch_pair.sv
module smb_scratch_pair
   import smb_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic              sel1_i,
   input  logic [LANE_W-1:0] lane_i,
   input  logic [DATA_W-1:0] data_i,
   output logic [WORD_W-1:0] word0_o,
   output logic [WORD_W-1:0] word1_o,
   output logic              flip31_o
);

   if (WORD_W % DATA_W != 0) begin : g_bad_width
      $error("scratch word width must be a whole number of bytes");
   end

   for (genvar b = 0; b < LANES; b++) begin : g_lane
      logic [DATA_W-1:0] w0_q, w1_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            w0_q <= '0;
            w1_q <= '0;
         end else if (wr_en_i && lane_i == LANE_W'(b)) begin
            if (sel1_i) w1_q <= data_i;
            else        w0_q <= data_i;
         end
      end

      assign word0_o[b*DATA_W +: DATA_W] = w0_q;
      assign word1_o[b*DATA_W +: DATA_W] = w1_q;
   end

   // top lane write to word 0 that changes the most significant bit
   assign flip31_o = wr_en_i && !sel1_i && lane_i == LANE_W'(LANES - 1)
                     && (data_i[DATA_W-1] != word0_o[WORD_W-1]);

   assert_idle_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en_i |=> ($stable(word0_o) && $stable(word1_o)))
      else $error("scratch word changed without a write");

   assert_other_word_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && sel1_i) |=> $stable(word0_o))
      else $error("word 0 changed on a word 1 write");

endmodule

// File: rtl/smb_irq.sv
module smb_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic trig_i,
   input  logic ack_i,
   output logic pend_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pend_o <= 1'b0;
      else if (trig_i) pend_o <= 1'b1;
      else if (ack_i)  pend_o <= 1'b0;
   end

   assert_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_o && !ack_i) |=> pend_o)
      else $error("pending flag dropped without acknowledge");

   assert_trig_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
      trig_i |=> pend_o)
      else $error("trigger lost");

   assert_ack_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && !trig_i) |=> !pend_o)
      else $error("acknowledge did not clear flag");

endmodule

// File: rtl/scratch_mailbox.sv
module scratch_mailbox
   import smb_pkg::*;
#(
   parameter int                NUM_NODES   = 2,
   parameter int                NODE_W      = 8,
   parameter logic [NODE_W-1:0] NODE_BASE   = 8'h04,
   parameter logic [NODE_W-1:0] TOGGLE_NODE = 8'h01
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        mode_conv_i,
   input  logic                        cmd_valid_i,
   input  logic [NODE_W-1:0]           cmd_node_i,
   input  logic [VERB_W-1:0]           cmd_verb_i,
   input  logic [DATA_W-1:0]           cmd_data_i,
   output logic                        rsp_valid_o,
   output logic [WORD_W-1:0]           rsp_data_o,
   output logic [NUM_NODES*WORD_W-1:0] sink_word0_o,
   output logic [NUM_NODES*WORD_W-1:0] sink_word1_o,
   output logic                        irq_pend_o,
   input  logic                        irq_ack_i
);

   localparam int ID_SPAN = 1 << NODE_W;

   if (NUM_NODES < 1) begin : g_bad_count
      $error("NUM_NODES must be at least one");
   end
   if (int'(NODE_BASE) + NUM_NODES > ID_SPAN) begin : g_bad_range
      $error("converter node ids overflow the node id width");
   end

   verb_dec_t             dec;
   logic [NUM_NODES-1:0]  hit;
   logic [NUM_NODES-1:0]  flip;
   logic [WORD_W-1:0]     rd_mux;
   logic                  trig_toggle, trig_verb, trig;

   smb_verb_dec u_dec (
      .verb_i (cmd_verb_i),
      .dec_o  (dec)
   );

   smb_node_sel #(
      .NUM_NODES   (NUM_NODES),
      .NODE_W      (NODE_W),
      .NODE_BASE   (NODE_BASE),
      .TOGGLE_NODE (TOGGLE_NODE)
   ) u_sel (
      .node_i (cmd_node_i),
      .conv_i (mode_conv_i),
      .hit_o  (hit)
   );

   for (genvar i = 0; i < NUM_NODES; i++) begin : g_pair
      smb_scratch_pair u_pair (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_en_i  (cmd_valid_i && dec.wr && hit[i]),
         .sel1_i   (dec.sel1),
         .lane_i   (dec.lane),
         .data_i   (cmd_data_i),
         .word0_o  (sink_word0_o[i*WORD_W +: WORD_W]),
         .word1_o  (sink_word1_o[i*WORD_W +: WORD_W]),
         .flip31_o (flip[i])
      );
   end

   always_comb begin
      rd_mux = '0;
      for (int i = 0; i < NUM_NODES; i++) begin
         if (hit[i]) begin
            rd_mux = rd_mux | (dec.sel1 ? sink_word1_o[i*WORD_W +: WORD_W]
                                        : sink_word0_o[i*WORD_W +: WORD_W]);
         end
      end
   end

   assign trig_toggle = !mode_conv_i && cmd_valid_i && (|(flip & hit));
   assign trig_verb   = mode_conv_i && cmd_valid_i && dec.raise && (|hit)
                        && (cmd_data_i != '0);
   assign trig        = trig_toggle || trig_verb;

   smb_irq u_irq (
      .clk    (clk),
      .rst_n  (rst_n),
      .trig_i (trig),
      .ack_i  (irq_ack_i),
      .pend_o (irq_pend_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid_o <= 1'b0;
         rsp_data_o  <= '0;
      end else begin
         rsp_valid_o <= cmd_valid_i;
         rsp_data_o  <= (cmd_valid_i && dec.rd) ? rd_mux : '0;
      end
   end

   assert_rsp_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid_i |=> rsp_valid_o)
      else $error("missing response strobe");

   assert_rsp_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_valid_i |=> !rsp_valid_o)
      else $error("response strobe without command");

   assert_nonread_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid_i && !dec.rd) |=> (rsp_data_o == '0))
      else $error("nonzero response to a non-read verb");

   assert_one_node_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit))
      else $error("several register pairs addressed at once");

   assert_toggle_raises_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_conv_i && !$past(mode_conv_i) && $changed(sink_word0_o[WORD_W-1]))
      |-> irq_pend_o)
      else $error("bit 31 change did not raise the interrupt");

   assert_toggle_no_verb_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_conv_i && !trig_toggle && !irq_pend_o) |=> !irq_pend_o)
      else $error("interrupt raised in toggle mode without bit 31 change");

endmodule

// File: tb/scratch_mailbox_tb.sv
module scratch_mailbox_tb;

   localparam int CLK_PERIOD = 10;
   localparam int N          = 2;
   localparam int BASE       = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          conv = 1'b0;
   logic          cv = 1'b0;
   logic [7:0]    node = '0;
   logic [11:0]   verb = '0;
   logic [7:0]    dat = '0;
   logic          ack = 1'b0;
   logic          rv;
   logic [31:0]   rd;
   logic [N*32-1:0] w0, w1;
   logic          irq;

   logic [31:0]   m0 [N];
   logic [31:0]   m1 [N];
   logic          mp, mrv;
   logic [31:0]   mrd;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   scratch_mailbox #(.NUM_NODES(N), .NODE_W(8), .NODE_BASE(8'(BASE)), .TOGGLE_NODE(8'h01)) u_dut (
      .clk(clk), .rst_n(rst_n), .mode_conv_i(conv), .cmd_valid_i(cv), .cmd_node_i(node),
      .cmd_verb_i(verb), .cmd_data_i(dat), .rsp_valid_o(rv), .rsp_data_o(rd),
      .sink_word0_o(w0), .sink_word1_o(w1), .irq_pend_o(irq), .irq_ack_i(ack)
   );

   task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic compare(string tag);
      chk(tag, "rsp_valid(R2)", {31'b0, rv}, {31'b0, mrv});
      chk(tag, "rsp_data(R3)", rd, mrd);
      chk(tag, "irq_pend(R11)", {31'b0, irq}, {31'b0, mp});
      for (int i = 0; i < N; i++) begin
         chk(tag, $sformatf("word0[%0d](R4)", i), w0[i*32 +: 32], m0[i]);
         chk(tag, $sformatf("word1[%0d](R4)", i), w1[i*32 +: 32], m1[i]);
      end
   endtask

   // behavioural reference: next state from the inputs now applied
   task automatic model_step();
      int b = -1;
      logic t = 1'b0;
      logic [31:0] r = '0;
      if (!conv) begin
         if (node == 8'h01) b = 0;
      end else if (int'(node) >= BASE && int'(node) < BASE + N) begin
         b = int'(node) - BASE;
      end
      if (cv && b >= 0) begin
         if (verb == 12'hFA6) r = m0[b];
         else if (verb == 12'hFAB) r = m1[b];
         else if (verb >= 12'hFA7 && verb <= 12'hFAA) begin
            int ln = int'(verb) - 'hFA7;
            if (!conv && ln == 3 && dat[7] != m0[b][31]) t = 1'b1;
            m0[b][ln*8 +: 8] = dat;
         end else if (verb >= 12'hFAC && verb <= 12'hFAF) begin
            int ln = int'(verb) - 'hFAC;
            m1[b][ln*8 +: 8] = dat;
         end else if (verb == 12'hF80 && conv && dat != 0) t = 1'b1;
      end
      mp  = t | (mp & ~ack);
      mrv = cv;
      mrd = r;
   endtask

   task automatic step(logic v, logic [7:0] n, logic [11:0] vb, logic [7:0] d,
                       logic a, string tag);
      cv = v; node = n; verb = vb; dat = d; ack = a;
      model_step();
      @(posedge clk);
      @(negedge clk);
      compare(tag);
   endtask

   task automatic cmd(logic [7:0] n, logic [11:0] vb, logic [7:0] d, string tag);
      step(1'b1, n, vb, d, 1'b0, tag);
   endtask

   task automatic idle(logic a, string tag);
      step(1'b0, 8'h00, 12'h000, 8'h00, a, tag);
   endtask

   task automatic do_reset(logic mode, string tag);
      rst_n = 1'b0; conv = mode; cv = 1'b0; ack = 1'b0;
      for (int i = 0; i < N; i++) begin m0[i] = '0; m1[i] = '0; end
      mp = 1'b0; mrv = 1'b0; mrd = '0;
      repeat (2) @(negedge clk);
      compare(tag);
      rst_n = 1'b1;
      idle(1'b0, tag);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      errors++;
      checks++;
      $display("FAIL watchdog R2 actual=hung expected=done");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      // toggle mode
      do_reset(1'b0, "R1 reset toggle mode");
      cmd(8'h01, 12'hFA7, 8'h34, "R4 lane0 word0");
      cmd(8'h01, 12'hFA8, 8'h12, "R4 lane1 word0");
      cmd(8'h01, 12'hFA9, 8'hAB, "R4 lane2 word0");
      cmd(8'h01, 12'hFAA, 8'h40, "R8 valid bit set, bit31 unchanged");
      cmd(8'h01, 12'hFA6, 8'h00, "R3 read word0");
      cmd(8'h01, 12'hFAC, 8'h11, "R4 lane0 word1");
      cmd(8'h01, 12'hFAD, 8'h22, "R4 lane1 word1");
      cmd(8'h01, 12'hFAE, 8'h33, "R4 lane2 word1");
      cmd(8'h01, 12'hFAF, 8'h44, "R4 lane3 word1");
      cmd(8'h01, 12'hFAB, 8'h00, "R3 read word1");
      cmd(8'h01, 12'hFA8, 8'h99, "R4 lane1 overwrite keeps others");
      cmd(8'h01, 12'hFAA, 8'h40, "R8 same bit31 no interrupt");
      cmd(8'h01, 12'hFAA, 8'hC0, "R8 bit31 rise raises");
      idle(1'b0, "R11 flag holds");
      idle(1'b1, "R11 ack clears");
      step(1'b1, 8'h01, 12'hFAA, 8'h40, 1'b1, "R11 fall trigger with ack stays set");
      idle(1'b0, "R11 still set");
      idle(1'b1, "R11 ack clears again");
      cmd(8'h04, 12'hFAA, 8'h80, "R6 other node write ignored");
      cmd(8'h04, 12'hFA6, 8'h00, "R6 other node reads zero");
      cmd(8'h01, 12'hF80, 8'h01, "R10 raise verb ignored in toggle mode");
      cmd(8'h01, 12'hFA5, 8'hFF, "R5 unknown verb");
      cmd(8'h01, 12'hFB0, 8'hFF, "R5 unknown verb above range");
      cmd(8'h01, 12'hFA6, 8'h00, "R5 word0 unchanged");
      idle(1'b0, "R2 no strobe when idle");

      // converter mode
      do_reset(1'b1, "R1 reset converter mode");
      cmd(8'h04, 12'hFA7, 8'h5A, "R7 node4 write");
      cmd(8'h05, 12'hFA7, 8'hA5, "R7 node5 write");
      cmd(8'h05, 12'hFAF, 8'h3C, "R7 node5 word1 lane3");
      cmd(8'h04, 12'hFA6, 8'h00, "R7 node4 read");
      cmd(8'h05, 12'hFAB, 8'h00, "R7 node5 read word1");
      cmd(8'h01, 12'hFA7, 8'h77, "R7 node1 ignored");
      cmd(8'h01, 12'hFA6, 8'h00, "R7 node1 reads zero");
      cmd(8'h06, 12'hFA6, 8'h00, "R7 node out of range");
      cmd(8'h04, 12'hFAA, 8'h80, "R9 bit31 change no interrupt");
      cmd(8'h04, 12'hF80, 8'h00, "R9 zero payload no interrupt");
      cmd(8'h06, 12'hF80, 8'h01, "R7 raise to absent node ignored");
      cmd(8'h05, 12'hF80, 8'h03, "R9 nonzero payload raises");
      idle(1'b0, "R11 holds in converter mode");
      step(1'b1, 8'h04, 12'hF80, 8'h01, 1'b1, "R11 raise with ack stays set");
      idle(1'b1, "R11 ack clears");
      cmd(8'h04, 12'hFA6, 8'h00, "R4 node4 word0 bit31 stored");

      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule